// File: doc/BRIEF.md
# GPIO Level-Sense Latch Detector

This block watches a port of general-purpose input pins and raises a wake or interrupt indication when any enabled pin sits at its chosen level. Each pin is configured to ignore its input, to sense a high level or to sense a low level, and its input buffer can be connected or disconnected. Raw pin levels pass through a synchronizer and then drive one live detect flag per pin.

A rising edge on a pin's live detect records that pin in a sticky capture register. Software clears that register by writing ones. A clear aimed at a pin whose detect is still high is refused. A summary flag, the latched detect, stays high while any captured bit is set. Its controller has three states: `LD_IDLE` (capture empty, flag low), `LD_ACTIVE` (flag high) and `LD_REPULSE` (flag forced low for one clock). The transitions are: IDLE→ACTIVE when a bit becomes set; ACTIVE→IDLE when the capture empties; ACTIVE→REPULSE when a clear write leaves bits set; REPULSE→ACTIVE when bits remain, or REPULSE→IDLE when they do not. This gives downstream logic a fresh rising edge after every clear that leaves work pending.

The port-wide detect output takes either the OR of the live detects or the latched detect, selected by a mode bit. A one-clock event pulse marks each rising edge of that output.

Top module: `gpio_sense_latch`

## Requirements
- R1: Pin configuration word n lives at address n (n below 32). Bits [1:0] select the sense mode: 0 = off, 1 = sense high, 2 = sense low, 3 = off. Bit 2 = 1 connects the input buffer. `pin_detect[n]` is high exactly when the buffer is connected and the synchronized level matches the mode.
- R2: Address 32 bit 0 selects the port detect source. With 0, `port_detect` is the OR of `pin_detect`. With 1, `port_detect` equals `latched_detect`.
- R3: A rising edge of `pin_detect[n]` sets capture bit n (read at address 33) at the next clock edge.
- R4: A capture bit is never cleared by its pin detect going low. It clears only through a write at address 33 with a one in that bit.
- R5: A write-one clear at address 33 on bit n has no effect while `pin_detect[n]` is high.
- R6: Outside the one-clock repulse, `latched_detect` is high exactly when the capture register is non-zero. It goes low once all bits are zero.
- R7: A non-zero write to address 33 that leaves any capture bit set drives `latched_detect` low for exactly one clock, after which it rises again.
- R8: `port_event` is a one-clock pulse on each rising edge of `port_detect`.
- R9: Enabling sensing on a pin whose condition already holds asserts its detect in the cycle right after the configuration write. An event results only if `port_detect` was low before that write.
- R10: A pin with its buffer disconnected reads 0 at address 34 (synchronized input levels, bit n = pin n) and never detects.
- R11: A raw pin change reaches `pin_detect` after the second rising clock edge, through a two-flop synchronizer.
- R12: After reset all configuration, the mode bit and the capture register are zero, and every detect output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 32 | Unsynchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_detect | output | 32 | Live per-pin detect flags |
| latched_detect | output | 1 | Capture-register summary flag |
| port_detect | output | 1 | Selected port-wide detect |
| port_event | output | 1 | One-clock pulse on port_detect rising |

## Verification
On every cycle, the assertions check the following:
- capture bits only fall after a clear write;
- a clear never drops a bit whose pin is detecting;
- the latched flag matches a non-empty capture register outside the repulse state;
- a repulse with no further clear returns to the active state;
- the event is a single cycle and coincides with a high port detect.

Some behaviours only the bench scenarios can show:
- the sense-mode decoding over the vector table;
- the exact two-edge synchronizer latency;
- the one-clock low gap seen at the port in latched mode;
- the suppressed event when a pin is enabled while the port is already detecting.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

    typedef enum logic [1:0] {
        SENSE_OFF  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_LOW  = 2'd2,
        SENSE_RSVD = 2'd3
    } sense_e;

    typedef struct packed {
        logic   connect;
        sense_e mode;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        LD_IDLE    = 2'd0,
        LD_ACTIVE  = 2'd1,
        LD_REPULSE = 2'd2
    } ld_state_e;

endpackage

// File: rtl/gsl_sync.sv
module gsl_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gsl_sense.sv
module gsl_sense
    import gsl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] lvl,
    input  pin_cfg_t [NUM_PINS-1:0] cfg,
    output logic [NUM_PINS-1:0] det,
    output logic [NUM_PINS-1:0] in_val
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        always_comb begin
            in_val[i] = lvl[i] & cfg[i].connect;
            det[i]    = 1'b0;
            if (cfg[i].connect) begin
                unique case (cfg[i].mode)
                    SENSE_HIGH: det[i] = lvl[i];
                    SENSE_LOW:  det[i] = ~lvl[i];
                    SENSE_OFF,
                    SENSE_RSVD: det[i] = 1'b0;
                    default:    det[i] = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/gsl_latch.sv
module gsl_latch
    import gsl_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] det,
    input  logic                clr_en,
    input  logic [NUM_PINS-1:0] clr_data,
    output logic [NUM_PINS-1:0] latch_q,
    output logic                ldetect
);
    logic [NUM_PINS-1:0] det_prev_q;
    logic [NUM_PINS-1:0] latch_d;
    logic [NUM_PINS-1:0] clr_mask;
    logic                clear_op;
    ld_state_e           state_q, state_d;

    always_comb begin
        clr_mask = clr_en ? (clr_data & ~det) : '0;
        latch_d  = (latch_q & ~clr_mask) | (det & ~det_prev_q);
        clear_op = clr_en && (|clr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_prev_q <= '0;
            latch_q    <= '0;
        end else begin
            det_prev_q <= det;
            latch_q    <= latch_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE:    if (|latch_d) state_d = LD_ACTIVE;
            LD_ACTIVE: begin
                if (latch_d == '0) state_d = LD_IDLE;
                else if (clear_op) state_d = LD_REPULSE;
            end
            LD_REPULSE: state_d = (|latch_d) ? LD_ACTIVE : LD_IDLE;
            default:    state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ldetect = (state_q == LD_ACTIVE);
    end

    // R4
    latch_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(latch_q) & ~latch_q)) |-> $past(clr_en));

    // R5
    clear_blocked_by_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((latch_q & $past(det & latch_q)) == $past(det & latch_q)));

    // R6
    ldetect_tracks_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != LD_REPULSE) |-> (ldetect == (latch_q != '0)));

    // R7
    repulse_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LD_REPULSE && !clr_en) |=> (state_q == LD_ACTIVE));
endmodule

// File: rtl/gpio_sense_latch.sv
module gpio_sense_latch
    import gsl_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] pin_detect,
    output logic                latched_detect,
    output logic                port_detect,
    output logic                port_event
);
    localparam int CFG_W = $bits(pin_cfg_t);
    localparam logic [ADDR_W-1:0] ADDR_MODE  = ADDR_W'(NUM_PINS);
    localparam logic [ADDR_W-1:0] ADDR_LATCH = ADDR_W'(NUM_PINS + 1);
    localparam logic [ADDR_W-1:0] ADDR_IN    = ADDR_W'(NUM_PINS + 2);

    pin_cfg_t [NUM_PINS-1:0] cfg_q;
    logic                    mode_latched_q;
    logic [NUM_PINS-1:0]     lvl_sync;
    logic [NUM_PINS-1:0]     in_val;
    logic [NUM_PINS-1:0]     latch_q;
    logic                    port_det_q;
    logic                    clr_en;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cfg_q[i] <= '0;
            else if (bus_wr && bus_addr == ADDR_W'(i))
                cfg_q[i] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             mode_latched_q <= 1'b0;
        else if (bus_wr && bus_addr == ADDR_MODE) mode_latched_q <= bus_wdata[0];
    end

    assign clr_en = bus_wr && (bus_addr == ADDR_LATCH);

    gsl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_raw),
        .q_out (lvl_sync)
    );

    gsl_sense #(.NUM_PINS(NUM_PINS)) u_sense (
        .lvl    (lvl_sync),
        .cfg    (cfg_q),
        .det    (pin_detect),
        .in_val (in_val)
    );

    gsl_latch #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .det      (pin_detect),
        .clr_en   (clr_en),
        .clr_data (bus_wdata[NUM_PINS-1:0]),
        .latch_q  (latch_q),
        .ldetect  (latched_detect)
    );

    always_comb begin
        port_detect = mode_latched_q ? latched_detect : (|pin_detect);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_det_q <= 1'b0;
        else        port_det_q <= port_detect;
    end

    assign port_event = port_detect & ~port_det_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_MODE)        bus_rdata = DATA_W'(cfg_q[bus_addr[$clog2(NUM_PINS)-1:0]]);
        else if (bus_addr == ADDR_MODE)  bus_rdata = DATA_W'(mode_latched_q);
        else if (bus_addr == ADDR_LATCH) bus_rdata = DATA_W'(latch_q);
        else if (bus_addr == ADDR_IN)    bus_rdata = DATA_W'(in_val);
    end

    // R8
    event_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_event |=> !port_event);

    // R8
    event_implies_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_event |-> port_detect);

    // R2
    latched_mode_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_latched_q |-> (port_detect == latched_detect));
endmodule

// File: tb/tb_gpio_sense_latch.sv
`timescale 1ns/1ps
module tb_gpio_sense_latch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_raw = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_detect;
    logic        latched_detect, port_detect, port_event;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_sense_latch dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_detect(pin_detect), .latched_detect(latched_detect),
        .port_detect(port_detect), .port_event(port_event)
    );

    // fields: cfg[4:2], level[1], expected detect[0]
    localparam logic [4:0] VEC [8] = '{
        {3'b101, 1'b1, 1'b1}, {3'b101, 1'b0, 1'b0},
        {3'b110, 1'b0, 1'b1}, {3'b110, 1'b1, 1'b0},
        {3'b100, 1'b1, 1'b0}, {3'b111, 1'b0, 1'b0},
        {3'b001, 1'b1, 1'b0}, {3'b010, 1'b0, 1'b0}
    };

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a; #0.2; d = bus_rdata;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R12 reset state
        rd(7'd33, r); chk(r == 0, "R12 latch", r, 0);
        rd(7'd5, r);  chk(r == 0, "R12 cfg", r, 0);
        chk(port_detect == 0 && latched_detect == 0 && pin_detect == 0, "R12 detects",
            {port_detect, latched_detect, |pin_detect}, 0);

        // R1 / R10 vector table on pin 5
        for (int v = 0; v < 8; v++) begin
            pin_raw[5] = VEC[v][1];
            wr(7'd5, {29'b0, VEC[v][4:2]});
            tick(); tick();
            chk(pin_detect[5] == VEC[v][0], "R1 sense decode", pin_detect[5], VEC[v][0]);
            rd(7'd34, r);
            chk(r[5] == (VEC[v][1] & VEC[v][4]), "R10 input read", r[5], VEC[v][1] & VEC[v][4]);
        end
        wr(7'd5, 0); pin_raw = '0; tick(); tick();
        wr(7'd33, 32'hFFFF_FFFF); tick();
        rd(7'd33, r); chk(r == 0, "R4 cleanup clear", r, 0);
        chk(latched_detect == 0, "R6 empty low", latched_detect, 0);

        // R11 synchronizer latency, R8 event, R3 capture
        wr(7'd1, 32'h5); wr(7'd2, 32'h5);
        pin_raw[1] = 1'b1; pin_raw[2] = 1'b1;
        tick();
        chk(pin_detect[1] == 0, "R11 after one edge", pin_detect[1], 0);
        tick();
        chk(pin_detect[1] == 1, "R11 after two edges", pin_detect[1], 1);
        chk(port_event == 1, "R8 event on rise", port_event, 1);
        tick();
        chk(port_event == 0, "R8 event one cycle", port_event, 0);
        rd(7'd33, r); chk(r == 32'h6, "R3 capture set", r, 32'h6);
        chk(latched_detect == 1, "R6 latched high", latched_detect, 1);

        // R4 detect drop keeps bit
        pin_raw[1] = 1'b0; tick(); tick(); tick();
        rd(7'd33, r); chk(r == 32'h6, "R4 bit kept after drop", r, 32'h6);

        // R5 + R7 clear of held pin refused, repulse
        wr(7'd33, 32'h4);
        rd(7'd33, r); chk(r == 32'h6, "R5 clear refused", r, 32'h6);
        chk(latched_detect == 0, "R7 repulse low", latched_detect, 0);
        tick();
        chk(latched_detect == 1, "R7 repulse high again", latched_detect, 1);

        // R7 clear pin1 leaves bit 2
        wr(7'd33, 32'h2);
        rd(7'd33, r); chk(r == 32'h4, "R4 clear by write", r, 32'h4);
        chk(latched_detect == 0, "R7 low one cycle", latched_detect, 0);
        tick();
        chk(latched_detect == 1, "R7 rises again", latched_detect, 1);

        // R2 latched mode: port follows latched, repulse gives new event
        wr(7'd32, 32'h1);
        chk(port_detect == 1, "R2 latched source", port_detect, 1);
        wr(7'd33, 32'h4);
        chk(port_detect == 0, "R2 port repulse low", port_detect, 0);
        tick();
        chk(port_event == 1, "R8 event after repulse", port_event, 1);

        // R6 clear all
        pin_raw[2] = 1'b0; tick(); tick(); tick();
        wr(7'd33, 32'h4);
        rd(7'd33, r); chk(r == 0, "R6 all cleared", r, 0);
        chk(latched_detect == 0 && port_detect == 0, "R6 latched low", latched_detect, 0);
        tick();
        chk(latched_detect == 0, "R6 stays low", latched_detect, 0);

        // R2 latched mode lags live detect by the capture edge
        pin_raw[2] = 1'b1; tick(); tick();
        chk(pin_detect[2] == 1 && port_detect == 0, "R2 latched lag", port_detect, 0);
        tick();
        chk(port_detect == 1 && port_event == 1, "R2 latched rise", {port_detect, port_event}, 2'b11);
        pin_raw[2] = 1'b0; tick(); tick(); tick();
        wr(7'd33, 32'h4); wr(7'd32, 0); tick();
        chk(port_detect == 0, "R2 default source", port_detect, 0);

        // R9 enable while condition already true
        pin_raw[7] = 1'b1; pin_raw[8] = 1'b1; tick(); tick(); tick();
        chk(port_detect == 0, "R9 not yet enabled", port_detect, 0);
        wr(7'd7, 32'h5);
        chk(pin_detect[7] == 1 && port_event == 1, "R9 immediate with event",
            {pin_detect[7], port_event}, 2'b11);
        tick();
        wr(7'd8, 32'h5);
        chk(pin_detect[8] == 1, "R9 second pin detects", pin_detect[8], 1);
        chk(port_event == 0, "R9 no event when port high", port_event, 0);

        // R10 disconnected pin never detects
        wr(7'd8, 32'h1); pin_raw[8] = 1'b1; tick(); tick();
        chk(pin_detect[8] == 0, "R10 disconnected no detect", pin_detect[8], 0);
        rd(7'd34, r); chk(r[8] == 0, "R10 disconnected reads 0", r[8], 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule